// File: doc/BRIEF.md
# BCD Calendar Timekeeper Register Bank

This block keeps a real-time calendar in packed BCD: seconds, minutes, hours in 24-hour form, day of the week, date, month and a two-digit year. A single-cycle pulse on the tick input, issued once per second, advances the counters. Month length follows the calendar, with 30-day and 31-day months and a February of 28 days, or 29 in a leap year.

The host never touches the running counters directly. It sees eight byte-wide holding registers through a synchronous read/write port, in the same way as ordinary memory. One clock after each tick, the holding registers are refreshed from the counters. The lowest byte is a control register. It lets the host stop the refresh to get a coherent snapshot while the counters keep running. It also lets the host stage new time values and commit them to the counters in one cycle. The control byte carries a six-bit calibration setting, which is stored only.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, the counters and the holding bytes read seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00, and the control byte reads 00.
- R2: The byte offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A read strobe returns the addressed byte with `host_rvalid` high on the next cycle, and `host_rvalid` stays low when there is no read.
- R3: Each tick advances the seconds. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into both the day of week (07 wraps to 01) and the date.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R5: In month 02 the date wraps after 29 when the BCD year is divisible by 4 (00 included), and after 28 otherwise.
- R6: One cycle after a tick, all seven holding bytes take the counter values, provided control bits 7 and 6 are both clear.
- R7: While control bit 6 (freeze) is set, the holding bytes are not refreshed but the counters keep counting. After the bit is cleared, the next tick shows the advanced time.
- R8: While control bit 7 (load) is set, the refresh stops and host writes to the time bytes are kept. A control write that takes bit 7 from 1 to 0 copies all holding bytes into the counters at that clock edge, and a tick in the same cycle is ignored.
- R9: Control bits 5:0 (calibration, bit 5 the sign) are stored and read back, and they have no effect on counting.
- R10: Bytes that are not valid BCD are loaded unchanged. A counter incremented at or above its last legal value wraps to its start value and carries.
- R11: Without a tick or a load, the counters do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Byte offset |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data |
| host_rvalid | output | 1 | Read data valid |

## Verification
The bench loads end-of-period times and checks each rollover: the year end, a 30-day month, and February in a leap year, a common year and year 00. A design that gets a month limit wrong shows the wrong date or month, and a wrong leap rule lands on 29 or 03/01 in the wrong year. The bench also freezes the holding bytes across several ticks: a leaking refresh changes the snapshot, and a counter that stops while frozen shows too small a step after release. Finally it commits a load in the same cycle as a tick, and it runs counters holding invalid BCD through a wrap, where an extra increment or a missed carry gives visibly wrong seconds, minutes or hours.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int NUM_UNITS  = 7;
   localparam int SEC_I      = 0;
   localparam int MIN_I      = 1;
   localparam int HR_I       = 2;
   localparam int DOW_I      = 3;
   localparam int DATE_I     = 4;
   localparam int MON_I      = 5;
   localparam int YR_I       = 6;
   localparam int LOAD_BIT   = 7;
   localparam int FREEZE_BIT = 6;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // tens*10 mod 4 equals 2*tens mod 4, so only tens[0] and ones[1:0] matter
   function automatic logic is_leap(input logic [7:0] yr);
      logic [1:0] m;
      m = yr[1:0] + {yr[4], 1'b0};
      return (m == 2'd0);
   endfunction

   function automatic logic [7:0] month_limit(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] unit_start(input int idx);
      return (idx == DOW_I || idx == DATE_I || idx == MON_I) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [7:0] unit_limit(input int idx);
      case (idx)
         SEC_I, MIN_I: return 8'h59;
         HR_I:         return 8'h23;
         DOW_I:        return 8'h07;
         MON_I:        return 8'h12;
         default:      return 8'h99;
      endcase
   endfunction
endpackage

// File: rtl/rtc_unit.sv
module rtc_unit #(
   parameter int          DATA_W = 8,
   parameter logic [7:0]  START  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic [DATA_W-1:0] limit,
   output logic [DATA_W-1:0] value,
   output logic              carry
);
   import rtc_pkg::*;

   if (DATA_W != 8) begin : g_bad_width
      $error("rtc_unit: DATA_W must be 8 for packed BCD");
   end

   assign carry = inc && (value >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= START;
      else if (load) value <= load_val;
      else if (inc)  value <= carry ? START : bcd_inc(value);
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
   parameter int DATA_W = 8
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        tick,
   input  logic                                        load,
   input  logic [rtc_pkg::NUM_UNITS-1:0][DATA_W-1:0]   load_vals,
   output logic [rtc_pkg::NUM_UNITS-1:0][DATA_W-1:0]   cnt
);
   import rtc_pkg::*;

   logic [NUM_UNITS-1:0]              inc;
   logic [NUM_UNITS-1:0]              carry;
   logic [NUM_UNITS-1:0][DATA_W-1:0]  limit;

   always_comb begin
      inc[SEC_I]  = tick;
      inc[MIN_I]  = carry[SEC_I];
      inc[HR_I]   = carry[MIN_I];
      inc[DOW_I]  = carry[HR_I];
      inc[DATE_I] = carry[HR_I];
      inc[MON_I]  = carry[DATE_I];
      inc[YR_I]   = carry[MON_I];
   end

   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
      if (i == DATE_I) begin : g_lim_dyn
         assign limit[i] = month_limit(cnt[MON_I], cnt[YR_I]);
      end else begin : g_lim_fix
         assign limit[i] = unit_limit(i);
      end

      rtc_unit #(.DATA_W(DATA_W), .START(unit_start(i))) u_unit (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc      (inc[i]),
         .load     (load),
         .load_val (load_vals[i]),
         .limit    (limit[i]),
         .value    (cnt[i]),
         .carry    (carry[i])
      );
   end
endmodule

// File: rtl/rtc_hold_bank.sv
module rtc_hold_bank #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter bit REG_READ = 1'b1
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       host_wr,
   input  logic                                       host_rd,
   input  logic [ADDR_W-1:0]                          host_addr,
   input  logic [DATA_W-1:0]                          host_wdata,
   input  logic                                       refresh_req,
   input  logic [rtc_pkg::NUM_UNITS-1:0][DATA_W-1:0]  cnt,
   output logic [rtc_pkg::NUM_UNITS-1:0][DATA_W-1:0]  hold,
   output logic [DATA_W-1:0]                          ctrl,
   output logic                                       load,
   output logic [DATA_W-1:0]                          host_rdata,
   output logic                                       host_rvalid
);
   import rtc_pkg::*;

   if ((2 ** ADDR_W) < (NUM_UNITS + 1)) begin : g_bad_addr
      $error("rtc_hold_bank: ADDR_W too small for eight bytes");
   end

   logic              ctrl_sel;
   logic              refresh;
   logic [DATA_W-1:0] rd_mux;

   assign ctrl_sel = (host_addr == '0);
   assign load     = host_wr && ctrl_sel && ctrl[LOAD_BIT] && !host_wdata[LOAD_BIT];
   assign refresh  = refresh_req && !ctrl[LOAD_BIT] && !ctrl[FREEZE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)                   ctrl <= '0;
      else if (host_wr && ctrl_sel) ctrl <= host_wdata;
   end

   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold[i] <= unit_start(i);
         else if (host_wr && (host_addr == ADDR_W'(i + 1)))
            hold[i] <= host_wdata;
         else if (refresh)
            hold[i] <= cnt[i];
      end
   end

   always_comb begin
      rd_mux = ctrl;
      for (int i = 0; i < NUM_UNITS; i++)
         if (host_addr == ADDR_W'(i + 1)) rd_mux = hold[i];
   end

   if (REG_READ) begin : g_reg_read
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
         end else begin
            host_rvalid <= host_rd;
            if (host_rd) host_rdata <= rd_mux;
         end
      end
   end else begin : g_comb_read
      assign host_rdata  = rd_mux;
      assign host_rvalid = host_rd;
   end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter bit REG_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid
);
   import rtc_pkg::*;

   logic [NUM_UNITS-1:0][DATA_W-1:0] cnt_q;
   logic [NUM_UNITS-1:0][DATA_W-1:0] hold_q;
   logic [DATA_W-1:0]                ctrl_q;
   logic                             load;
   logic                             tick_d;

   always_ff @(posedge clk) begin
      if (!rst_n) tick_d <= 1'b0;
      else        tick_d <= tick_1hz;
   end

   rtc_calendar #(.DATA_W(DATA_W)) u_cal (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_1hz),
      .load      (load),
      .load_vals (hold_q),
      .cnt       (cnt_q)
   );

   rtc_hold_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_READ(REG_READ)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_rd     (host_rd),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .refresh_req (tick_d),
      .cnt         (cnt_q),
      .hold        (hold_q),
      .ctrl        (ctrl_q),
      .load        (load),
      .host_rdata  (host_rdata),
      .host_rvalid (host_rvalid)
   );
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
   parameter int DATA_W   = 8,
   parameter bit REG_READ = 1'b1
) (
   input logic                                       clk,
   input logic                                       rst_n,
   input logic                                       tick_1hz,
   input logic                                       host_wr,
   input logic                                       host_rd,
   input logic                                       host_rvalid,
   input logic                                       load,
   input logic [DATA_W-1:0]                          ctrl,
   input logic [rtc_pkg::NUM_UNITS-1:0][DATA_W-1:0]  cnt,
   input logic [rtc_pkg::NUM_UNITS-1:0][DATA_W-1:0]  hold
);
   import rtc_pkg::*;

   if (REG_READ) begin : g_rd_chk
      assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
         host_rd |=> host_rvalid);
      assert_rvalid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !host_rd |=> !host_rvalid);
   end

   assert_counters_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_1hz && !load) |=> $stable(cnt));

   assert_load_copies_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(hold)));

   assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[FREEZE_BIT] && !host_wr) |=> $stable(hold));

   assert_ctrl_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> $stable(ctrl));
endmodule

bind rtc_regbank rtc_regbank_chk #(.DATA_W(DATA_W), .REG_READ(REG_READ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_1hz    (tick_1hz),
   .host_wr     (host_wr),
   .host_rd     (host_rd),
   .host_rvalid (host_rvalid),
   .load        (load),
   .ctrl        (ctrl_q),
   .cnt         (cnt_q),
   .hold        (hold_q)
);

// File: tb/rtc_regbank_tb_top.sv
module rtc_regbank_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_rvalid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #5 clk = ~clk;

   rtc_regbank dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_1hz    (tick_1hz),
      .host_wr     (host_wr),
      .host_rd     (host_rd),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .host_rdata  (host_rdata),
      .host_rvalid (host_rvalid)
   );

   // monitor: pops expected bytes as read data comes out
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2 unexpected read data act=%h exp=none", host_rdata);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (host_rdata !== e) begin
               errors++;
               $display("FAIL %s act=%h exp=%h", t, host_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic tick1();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] y);
      wr(3'd0, 8'h80);
      wr(3'd1, s); wr(3'd2, m); wr(3'd3, h);
      wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, y);
      wr(3'd0, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, 8'h00, "R1 ctrl");
      rd(3'd1, 8'h00, "R1 sec");
      rd(3'd2, 8'h00, "R1 min");
      rd(3'd3, 8'h00, "R1 hour");
      rd(3'd4, 8'h01, "R1 dow");
      rd(3'd5, 8'h01, "R1 date");
      rd(3'd6, 8'h01, "R1 month");
      rd(3'd7, 8'h00, "R1 year");

      // R3 R6 single tick
      tick1();
      rd(3'd1, 8'h01, "R3 R6 sec after tick");

      // R3 R4 R8 year-end rollover
      wr(3'd0, 8'h80); wr(3'd4, 8'h07);
      set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
      tick1();
      rd(3'd1, 8'h00, "R3 sec wrap");
      rd(3'd2, 8'h00, "R3 min wrap");
      rd(3'd3, 8'h00, "R3 hour wrap");
      rd(3'd4, 8'h01, "R3 dow wrap");
      rd(3'd5, 8'h01, "R4 date wrap");
      rd(3'd6, 8'h01, "R4 month wrap");
      rd(3'd7, 8'h00, "R4 year wrap");

      // R4 30-day month
      set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h24);
      tick1();
      rd(3'd5, 8'h01, "R4 april 30 date");
      rd(3'd6, 8'h05, "R4 april 30 month");
      rd(3'd4, 8'h02, "R3 dow step");

      // R5 february
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
      tick1();
      rd(3'd5, 8'h29, "R5 leap 24 date");
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
      tick1();
      rd(3'd5, 8'h01, "R5 common 23 date");
      rd(3'd6, 8'h03, "R5 common 23 month");
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00);
      tick1();
      rd(3'd5, 8'h29, "R5 year 00 date");
      set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h00);
      tick1();
      rd(3'd5, 8'h01, "R5 feb 29 date");
      rd(3'd6, 8'h03, "R5 feb 29 month");

      // R7 freeze
      wr(3'd0, 8'h40);
      tick1(); tick1(); tick1();
      rd(3'd1, 8'h00, "R7 frozen sec");
      rd(3'd0, 8'h40, "R7 ctrl readback");
      wr(3'd0, 8'h00);
      tick1();
      rd(3'd1, 8'h04, "R7 sec after release");

      // R9 calibration
      wr(3'd0, 8'h25);
      rd(3'd0, 8'h25, "R9 cal readback");
      tick1();
      rd(3'd1, 8'h05, "R9 counting with cal");
      wr(3'd0, 8'h3F);
      rd(3'd0, 8'h3F, "R9 cal full");
      wr(3'd0, 8'h00);

      // R8 load mode keeps host bytes, load beats tick
      wr(3'd0, 8'h80);
      wr(3'd1, 8'h10);
      tick1();
      rd(3'd1, 8'h10, "R8 no refresh while load set");
      @(negedge clk);
      host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'h00; tick_1hz = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; tick_1hz = 1'b0;
      @(negedge clk);
      rd(3'd1, 8'h10, "R8 tick ignored on load");
      tick1();
      rd(3'd1, 8'h11, "R8 counting from loaded");

      // R10 invalid BCD
      wr(3'd0, 8'h80);
      wr(3'd1, 8'h5A); wr(3'd2, 8'h7B); wr(3'd3, 8'h05);
      wr(3'd0, 8'h00);
      rd(3'd1, 8'h5A, "R10 invalid kept");
      tick1();
      rd(3'd1, 8'h00, "R10 sec wrap");
      rd(3'd2, 8'h00, "R10 min wrap");
      rd(3'd3, 8'h06, "R10 hour carry");

      // R11 idle, R2 no rvalid without read
      repeat (30) @(negedge clk);
      checks++;
      if (host_rvalid !== 1'b0) begin
         errors++;
         $display("FAIL R2 idle rvalid act=%b exp=0", host_rvalid);
      end
      rd(3'd1, 8'h00, "R11 sec idle");
      rd(3'd3, 8'h06, "R11 hour idle");

      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2 missing reads act=%0d exp=0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule